// File: doc/BRIEF.md
# Grouped Violation Record Shift-Sync Unit

This unit keeps one captured access-permission violation per slave group and releases the details to software only through a serial transfer. A checker elsewhere on the chip raises a capture strobe with the group index and the offending transaction's master, domain, direction and 36-bit address. If that group has nothing pending, the unit stores the record and sets the group's bit in a pending bitmap. While any bit in that bitmap is set, an interrupt line is held high.

Software services the groups one at a time. It reads the pending bitmap and writes a one-hot select naming one group. It then writes 1 to a control register. The sequencer moves the chosen 64-bit record into two shared debug registers, one bit per clock. Once the whole record has arrived, control reads back 0x3. Software reads the two debug words, writes 0 to control and clears the group's pending bit with a write-one-to-clear. All access goes through a plain 32-bit register port: write enable, address and write data, with read data returned combinationally from the address.

Top module: `vio_shift_unit`

## Requirements
- R1: After reset, the pending bitmap, all stored records, the select register, the control readback and both debug words are zero, and `irq` is low.
- R2: A capture strobe for a group whose pending bit is 0 stores that record and sets the group's bit in the status register at 0xF10 on the next clock. `irq` is high in every cycle in which any status bit is set.
- R3: A capture strobe for a group that is already pending is dropped. The record stored first is the one later transferred.
- R4: Writing 0xF10 clears every status bit whose write-data bit is 1. Bits written 0 keep their value.
- R5: The select register at 0xF14 reads back the value written in bits NUM_GROUPS-1:0. A transfer uses only the lowest set bit. If that group is not pending, or no bit is set, the transfer loads an all-zero record.
- R6: From idle, writing bit 0 = 1 to the control register at 0xF20 starts a transfer. Control reads 0x1 for exactly 64 cycles, shifting the record into the debug pair one bit per clock with record bit 0 entering first at the top. After that it reads 0x3 (bit 0 start, bit 1 done).
- R7: A write of bit 0 = 1 to control while a transfer is shifting or done has no effect on the control readback or on the shift.
- R8: Writing control with bit 0 = 0 returns the unit to idle from either shifting or done, so control reads 0. The debug words keep their contents.
- R9: Debug word 0 at 0x900 holds master ID in bits 15:0, domain ID in 21:16, the write flag in 22, the read flag in 23 and address bits 35:32 in 27:24. Bits 31:28 read 0. Debug word 1 at 0x904 holds address bits 31:0.
- R10: Reads of an unmapped offset return 0. Writes to the debug words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| cap_valid | input | 1 | Violation capture strobe |
| cap_group | input | GW (3) | Group index of the violation |
| cap_master | input | 16 | Bus master ID |
| cap_domain | input | 6 | Domain ID |
| cap_is_write | input | 1 | Violating access was a write |
| cap_is_read | input | 1 | Violating access was a read |
| cap_addr | input | 36 | Violating address |
| irq | output | 1 | High while any group is pending |

## Verification
A corrupted pending bit shows on `irq` and in the 0xF10 readback in the cycle after the faulty edge. A broken group pick or an overwritten record shows as wrong debug words as soon as the transfer completes. A miscounted sequencer shows in the control readback within the 64-cycle shift window, either as an early or late 0x3 or as a failure to return to 0. Because the debug pair changes every shifting cycle, a wrong shift direction or bit order shows in the debug readback during the transfer itself.

// File: rtl/vsu_pkg.sv
package vsu_pkg;
  localparam int REC_W = 64;

  localparam logic [11:0] OFS_DBG_LO = 12'h900;
  localparam logic [11:0] OFS_DBG_HI = 12'h904;
  localparam logic [11:0] OFS_STATUS = 12'hF10;
  localparam logic [11:0] OFS_SELECT = 12'hF14;
  localparam logic [11:0] OFS_CTRL   = 12'hF20;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_DONE  = 2'd2
  } seq_state_e;

  // Packs one capture into the 64-bit record: low word is debug word 0.
  function automatic logic [REC_W-1:0] pack_record(
    input logic [15:0] master,
    input logic [5:0]  domain,
    input logic        is_wr,
    input logic        is_rd,
    input logic [35:0] addr
  );
    logic [31:0] lo;
    lo = {4'b0000, addr[35:32], is_rd, is_wr, domain, master};
    return {addr[31:0], lo};
  endfunction
endpackage

// File: rtl/vsu_record_store.sv
module vsu_record_store #(
  parameter int NUM_GROUPS = 8,
  parameter int GW         = 3,
  parameter int REC_W      = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cap_valid,
  input  logic [GW-1:0]         cap_group,
  input  logic [REC_W-1:0]      cap_rec,
  input  logic                  clr_en,
  input  logic [NUM_GROUPS-1:0] clr_mask,
  input  logic                  rd_valid,
  input  logic [GW-1:0]         rd_idx,
  output logic [REC_W-1:0]      rd_rec,
  output logic [NUM_GROUPS-1:0] pending
);
  logic [NUM_GROUPS-1:0] pend_q, pend_d;
  logic [NUM_GROUPS-1:0] accept;
  logic [REC_W-1:0]      rec_q [NUM_GROUPS];

  // A capture is taken only when the group had nothing pending before the edge.
  always_comb begin
    accept = '0;
    if (cap_valid && (int'(cap_group) < NUM_GROUPS))
      accept[cap_group] = ~pend_q[cap_group];
  end

  always_comb begin
    pend_d = pend_q;
    if (clr_en)
      pend_d = pend_d & ~clr_mask;
    pend_d = pend_d | accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= '0;
    else
      pend_q <= pend_d;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_rec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        rec_q[g] <= '0;
      else if (accept[g])
        rec_q[g] <= cap_rec;
    end
  end

  always_comb begin
    rd_rec = '0;
    if (rd_valid && (int'(rd_idx) < NUM_GROUPS) && pend_q[rd_idx])
      rd_rec = rec_q[rd_idx];
  end

  assign pending = pend_q;

  // R4: every pending bit named in a clear write is low afterwards
  p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((pend_q & $past(clr_mask & pend_q)) == '0));

  // R2: a capture for an idle group sets its bit
  p_capture_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !pend_q[cap_group]) |=> pend_q[$past(cap_group)]);

  // R3: a capture for a pending group leaves the stored record untouched
  p_first_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && pend_q[cap_group]) |=>
      (rec_q[$past(cap_group)] == $past(rec_q[cap_group])));
endmodule

// File: rtl/vsu_shift_seq.sv
module vsu_shift_seq
  import vsu_pkg::*;
#(
  parameter int REC_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic [REC_W-1:0] load_rec,
  output logic [REC_W-1:0] dbg,
  output logic             running,
  output logic             done
);
  localparam int CW = $clog2(REC_W);
  localparam logic [CW-1:0] LAST = CW'(REC_W - 1);

  seq_state_e       st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [REC_W-1:0] src_q, src_d;
  logic [REC_W-1:0] dbg_q, dbg_d;
  logic             load_en, shift_en;

  assign load_en  = (st_q == SQ_IDLE) && start_req;
  assign shift_en = (st_q == SQ_SHIFT) && !stop_req;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    src_d = src_q;
    dbg_d = dbg_q;
    case (st_q)
      SQ_IDLE: begin
        if (start_req) begin
          st_d  = SQ_SHIFT;
          cnt_d = '0;
          src_d = load_rec;
        end
      end
      SQ_SHIFT: begin
        if (stop_req) begin
          st_d = SQ_IDLE;
        end else begin
          dbg_d = {src_q[0], dbg_q[REC_W-1:1]};
          src_d = src_q >> 1;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST)
            st_d = SQ_DONE;
        end
      end
      SQ_DONE: begin
        if (stop_req)
          st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      st_q <= SQ_IDLE;
    else
      st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      src_q <= '0;
    end else if (load_en || shift_en) begin
      cnt_q <= cnt_d;
      src_q <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      dbg_q <= '0;
    else if (shift_en)
      dbg_q <= dbg_d;
  end

  assign dbg     = dbg_q;
  assign running = (st_q == SQ_SHIFT);
  assign done    = (st_q == SQ_DONE);

  // Checker counter: shifting cycles since the last idle state
  logic [CW:0] chk_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chk_run <= '0;
    else if (st_q == SQ_IDLE)
      chk_run <= '0;
    else if (shift_en)
      chk_run <= chk_run + 1'b1;
  end

  // R6: done rises only after the full record has been moved
  p_done_after_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (chk_run == (CW+1)'(REC_W)));

  // R7: start while shifting does not stop the transfer
  p_start_in_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && start_req) |=> (st_q != SQ_IDLE));

  // R7: start while done keeps done and the debug contents
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start_req) |=> (done && $stable(dbg_q)));

  // R8: a stop write always lands in idle, debug contents kept
  p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |=> ((st_q == SQ_IDLE) && $stable(dbg_q)));
endmodule

// File: rtl/vio_shift_unit.sv
module vio_shift_unit
  import vsu_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int GW         = $clog2(NUM_GROUPS),
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cap_valid,
  input  logic [GW-1:0]     cap_group,
  input  logic [15:0]       cap_master,
  input  logic [5:0]        cap_domain,
  input  logic              cap_is_write,
  input  logic              cap_is_read,
  input  logic [35:0]       cap_addr,
  output logic              irq
);
  logic                  wr_status, wr_select, wr_ctrl;
  logic [NUM_GROUPS-1:0] sel_q, sel_d;
  logic [GW-1:0]         low_idx;
  logic                  sel_any;
  logic [REC_W-1:0]      cap_rec, pick_rec, dbg;
  logic [NUM_GROUPS-1:0] pending;
  logic                  running, done;
  logic                  start_req, stop_req;

  assign wr_status = bus_wen && (bus_addr == ADDR_W'(OFS_STATUS));
  assign wr_select = bus_wen && (bus_addr == ADDR_W'(OFS_SELECT));
  assign wr_ctrl   = bus_wen && (bus_addr == ADDR_W'(OFS_CTRL));
  assign start_req = wr_ctrl && bus_wdata[0];
  assign stop_req  = wr_ctrl && !bus_wdata[0];

  assign cap_rec = pack_record(cap_master, cap_domain, cap_is_write,
                               cap_is_read, cap_addr);

  always_comb begin
    sel_d = sel_q;
    if (wr_select)
      sel_d = bus_wdata[NUM_GROUPS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sel_q <= '0;
    else if (wr_select)
      sel_q <= sel_d;
  end

  // Lowest set bit of the select register wins.
  always_comb begin
    low_idx = '0;
    for (int i = NUM_GROUPS - 1; i >= 0; i--)
      if (sel_q[i])
        low_idx = GW'(i);
  end
  assign sel_any = |sel_q;

  vsu_record_store #(
    .NUM_GROUPS (NUM_GROUPS),
    .GW         (GW),
    .REC_W      (REC_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_valid (cap_valid),
    .cap_group (cap_group),
    .cap_rec   (cap_rec),
    .clr_en    (wr_status),
    .clr_mask  (bus_wdata[NUM_GROUPS-1:0]),
    .rd_valid  (sel_any),
    .rd_idx    (low_idx),
    .rd_rec    (pick_rec),
    .pending   (pending)
  );

  vsu_shift_seq #(
    .REC_W (REC_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .stop_req  (stop_req),
    .load_rec  (pick_rec),
    .dbg       (dbg),
    .running   (running),
    .done      (done)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_DBG_LO))
      bus_rdata = dbg[31:0];
    else if (bus_addr == ADDR_W'(OFS_DBG_HI))
      bus_rdata = dbg[63:32];
    else if (bus_addr == ADDR_W'(OFS_STATUS))
      bus_rdata = 32'(pending);
    else if (bus_addr == ADDR_W'(OFS_SELECT))
      bus_rdata = 32'(sel_q);
    else if (bus_addr == ADDR_W'(OFS_CTRL))
      bus_rdata = {30'd0, done, running | done};
  end

  assign irq = |pending;

  // R2: the interrupt only rises after a capture strobe
  p_irq_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cap_valid));

  // R9: reserved field of debug word 0 reads zero
  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_DBG_LO)) |-> (bus_rdata[31:28] == 4'd0));

  // R5: the select register only changes through its own write
  p_select_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_select |=> $stable(sel_q));
endmodule

// File: tb/sim_vio_shift_unit.sv
`timescale 1ns/1ps
module sim_vio_shift_unit;
  localparam int NG = 8;
  localparam int GW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_valid = 1'b0;
  logic [GW-1:0] cap_group = '0;
  logic [15:0] cap_master = '0;
  logic [5:0]  cap_domain = '0;
  logic        cap_is_write = 1'b0;
  logic        cap_is_read = 1'b0;
  logic [35:0] cap_addr = '0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  vio_shift_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_valid(cap_valid),
    .cap_group(cap_group), .cap_master(cap_master), .cap_domain(cap_domain),
    .cap_is_write(cap_is_write), .cap_is_read(cap_is_read),
    .cap_addr(cap_addr), .irq(irq)
  );

  // ---------------- reference model ----------------
  logic [NG-1:0] m_pend;
  logic [NG-1:0] m_sel;
  logic [63:0]   m_rec [NG];
  int            m_st;
  int            m_cnt;
  logic [63:0]   m_src;
  logic [63:0]   m_dbg;

  always @(posedge clk or negedge rst_n) begin : model
    logic [NG-1:0] p_old;
    int idx;
    if (!rst_n) begin
      m_pend = '0; m_sel = '0; m_st = 0; m_cnt = 0; m_src = '0; m_dbg = '0;
      for (int g = 0; g < NG; g++) m_rec[g] = '0;
    end else begin
      p_old = m_pend;
      if (bus_wen && bus_addr == 12'hF10) m_pend = m_pend & ~bus_wdata[NG-1:0];
      if (cap_valid && !p_old[cap_group]) begin
        m_pend[cap_group] = 1'b1;
        m_rec[cap_group] = {cap_addr[31:0], 4'h0, cap_addr[35:32], cap_is_read,
                            cap_is_write, cap_domain, cap_master};
      end
      if (m_st == 0) begin
        if (bus_wen && bus_addr == 12'hF20 && bus_wdata[0]) begin
          idx = -1;
          for (int i = NG - 1; i >= 0; i--) if (m_sel[i]) idx = i;
          m_src = (idx >= 0 && p_old[idx]) ? m_rec[idx] : 64'd0;
          m_st = 1; m_cnt = 0;
        end
      end else if (m_st == 1) begin
        if (bus_wen && bus_addr == 12'hF20 && !bus_wdata[0]) m_st = 0;
        else begin
          m_dbg = {m_src[0], m_dbg[63:1]};
          m_src = m_src >> 1;
          m_cnt++;
          if (m_cnt == 64) m_st = 2;
        end
      end else begin
        if (bus_wen && bus_addr == 12'hF20 && !bus_wdata[0]) m_st = 0;
      end
      if (bus_wen && bus_addr == 12'hF14) m_sel = bus_wdata[NG-1:0];
    end
  end

  function automatic logic [31:0] model_read(input logic [11:0] a);
    case (a)
      12'h900: return m_dbg[31:0];
      12'h904: return m_dbg[63:32];
      12'hF10: return 32'(m_pend);
      12'hF14: return 32'(m_sel);
      12'hF20: return (m_st == 0) ? 32'd0 : (m_st == 1) ? 32'd1 : 32'd3;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h900, 12'h904: return "R9";
      12'hF10: return "R4";
      12'hF14: return "R5";
      12'hF20: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(tag_of(bus_addr), bus_rdata, model_read(bus_addr));
      check("R2", 32'(irq), 32'(m_pend != '0));
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic capture(input logic [GW-1:0] g, input logic [15:0] m,
                         input logic [5:0] dom, input logic w, input logic r,
                         input logic [35:0] a);
    @(posedge clk); #1;
    cap_valid = 1'b1; cap_group = g; cap_master = m; cap_domain = dom;
    cap_is_write = w; cap_is_read = r; cap_addr = a;
    @(posedge clk); #1;
    cap_valid = 1'b0;
  endtask

  // Starts a transfer and returns the number of cycles control read 0x1.
  task automatic run_transfer(output int shifts);
    logic [31:0] v;
    bus_write(12'hF20, 32'h1);
    shifts = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      v = bus_rdata;
      if (v == 32'h1) shifts++;
      else break;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    bus_read(12'hF10, v); check("R1", v, 32'h0);
    bus_read(12'hF14, v); check("R1", v, 32'h0);
    bus_read(12'hF20, v); check("R1", v, 32'h0);
    bus_read(12'h900, v); check("R1", v, 32'h0);
    bus_read(12'h904, v); check("R1", v, 32'h0);
    check("R1", 32'(irq), 32'h0);

    // R2: captures into groups 2 and 5
    capture(3'd2, 16'hBEEF, 6'h15, 1'b1, 1'b0, 36'hA_1234_5678);
    capture(3'd5, 16'h0001, 6'h3F, 1'b0, 1'b1, 36'hF_FFFF_0000);
    bus_read(12'hF10, v); check("R2", v, 32'h24);
    check("R2", 32'(irq), 32'h1);

    // R3: second capture to pending group 2 is dropped
    capture(3'd2, 16'h1111, 6'h01, 1'b0, 1'b1, 36'h0_0000_0004);
    bus_read(12'hF10, v); check("R3", v, 32'h24);

    // R5: multi-bit select picks the lowest group (2)
    bus_write(12'hF14, 32'h24);
    bus_read(12'hF14, v); check("R5", v, 32'h24);
    run_transfer(n);
    check("R6", 32'(n), 32'd64);
    check("R6", bus_rdata, 32'h3);
    bus_read(12'h900, v); check("R9", v, 32'h0A55BEEF);
    bus_read(12'h904, v); check("R3", v, 32'h12345678);

    // R7: start while done is ignored
    bus_write(12'hF20, 32'h1);
    bus_read(12'hF20, v); check("R7", v, 32'h3);
    bus_read(12'h900, v); check("R7", v, 32'h0A55BEEF);

    // R8: stop from done, debug kept
    bus_write(12'hF20, 32'h0);
    bus_read(12'hF20, v); check("R8", v, 32'h0);
    bus_read(12'h904, v); check("R8", v, 32'h12345678);

    // R4: write-one-to-clear, zeros keep
    bus_write(12'hF10, 32'h04);
    bus_read(12'hF10, v); check("R4", v, 32'h20);
    bus_write(12'hF10, 32'h00);
    bus_read(12'hF10, v); check("R4", v, 32'h20);

    // R5: non-pending group loads zeros
    bus_write(12'hF14, 32'h04);
    run_transfer(n);
    check("R6", 32'(n), 32'd64);
    bus_read(12'h900, v); check("R5", v, 32'h0);
    bus_read(12'h904, v); check("R5", v, 32'h0);
    bus_write(12'hF20, 32'h0);

    // R7: start during shifting is ignored; group 5 transfer
    bus_write(12'hF14, 32'h20);
    bus_write(12'hF20, 32'h1);
    repeat (5) @(posedge clk);
    bus_write(12'hF20, 32'h1);
    bus_read(12'hF20, v); check("R7", v, 32'h1);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (bus_rdata == 32'h3) break;
    end
    check("R7", bus_rdata, 32'h3);
    bus_read(12'h900, v); check("R9", v, 32'h0FBF0001);
    bus_read(12'h904, v); check("R9", v, 32'hFFFF0000);
    bus_write(12'hF20, 32'h0);

    // R8: abort mid-shift
    bus_write(12'hF20, 32'h1);
    repeat (10) @(posedge clk);
    bus_write(12'hF20, 32'h0);
    bus_read(12'hF20, v); check("R8", v, 32'h0);

    // R10: debug writes ignored, unmapped reads zero
    bus_write(12'h900, 32'hFFFF_FFFF);
    bus_read(12'h100, v); check("R10", v, 32'h0);
    bus_read(12'h904, v); check("R10", v, model_read(12'h904));

    // R2: last clear drops irq
    bus_write(12'hF10, 32'hFF);
    bus_read(12'hF10, v); check("R4", v, 32'h0);
    check("R2", 32'(irq), 32'h0);

    repeat (4) @(posedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule